// File: doc/BRIEF.md
# Reservation Station Pool with Result Broadcast

This block is the scheduling core of a small out-of-order integer unit. A single issue port takes one decoded instruction per cycle. The supported operations are load word, store word, add-immediate, multiply and branch-if-not-equal. Each instruction is placed into a free station of its class. There are three load stations, three store stations, three add stations (which also run the branch) and two multiply stations.

A 32-entry register status table holds, for each architectural register, either a value or the tag of the station that will produce it. An issued instruction copies its ready operands and records the producer tag of any operand that is not ready. Once nothing is pending, the station counts down a fixed latency. A finished station then wins a single shared result broadcast. That broadcast fills waiting operands and register entries and frees the station.

Memory sits outside the block and is reached through a combinational read port and a write port. A load reads at its broadcast step, and a store writes at its broadcast step.

Top module: `rsp_pool`

## Requirements
- R1: After reset all stations are free, every register status entry reads tag 0 with value 0, and no broadcast is driven.
- R2: Tags are station numbers plus one: 1-3 load, 4-6 store, 7-9 add/branch, 10-11 multiply; tag 0 means ready. Issue takes the lowest-numbered free station of the class named by `iss_op` (0 load, 1 store, 2 add-immediate, 3 multiply, 4 branch-if-not-equal) and reports its tag on `iss_tag`.
- R3: When `iss_valid` is high and no station of the class is free, `iss_stall` is high. No station and no register entry changes in that cycle, and the held instruction is accepted in the first cycle a station of its class is free.
- R4: At issue, a source whose status holds a value is copied. A source whose producer is broadcasting in that same cycle takes the broadcast data. Any other source records the producer tag. Load, add-immediate and multiply set the status of `rd` to the new tag, except when `rd` is 0, which always reads value 0 with tag 0.
- R5: With all operands ready at issue, the broadcast appears this many cycles after the issue edge: 2 for load, store and add-immediate, 10 for multiply, and 1 for the branch.
- R6: A station waiting on operands loads its counter at the edge that captures its last operand. It broadcasts 2 cycles later, or 10 for multiply; a woken branch also takes 2.
- R7: A broadcast writes its data into every register entry whose tag matches and clears that tag. An entry already re-tagged by a later issue keeps the newer tag and value.
- R8: At most one station broadcasts per cycle; among finished stations the lowest tag wins and the rest wait unchanged.
- R9: A store broadcast drives `mem_wr_en` with the address rs1 value plus the sign-extended immediate and the data operand, which is also the broadcast data.
- R10: A load broadcast drives `mem_rd_addr` with rs1 value plus the sign-extended immediate and broadcasts `mem_rd_data`.
- R11: Add-immediate returns rs1 plus the sign-extended 12-bit immediate modulo 2^32. Multiply returns the low 32 bits of the signed product. The branch broadcasts 1 when its operands differ and 0 otherwise.
- R12: A station is free again in the cycle after its broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Instruction presented for issue |
| iss_op | input | 3 | Operation code |
| iss_rd | input | 5 | Destination register |
| iss_rs1 | input | 5 | First source / base register |
| iss_rs2 | input | 5 | Second source / store data register |
| iss_imm | input | 12 | Signed immediate |
| iss_stall | output | 1 | Class full; hold the instruction |
| iss_tag | output | 4 | Tag of the station being allocated |
| cdb_valid | output | 1 | Result broadcast this cycle |
| cdb_tag | output | 4 | Tag of the broadcasting station |
| cdb_data | output | 32 | Broadcast data |
| mem_rd_addr | output | 32 | Load address during a load broadcast, else 0 |
| mem_rd_data | input | 32 | Combinational read data for mem_rd_addr |
| mem_wr_en | output | 1 | Store write strobe |
| mem_wr_addr | output | 32 | Store address |
| mem_wr_data | output | 32 | Store data |
| rf_sel | input | 5 | Register status read select |
| rf_tag | output | 4 | Tag of the selected entry |
| rf_value | output | 32 | Value of the selected entry |

## Verification
The checks assume the issue source keeps `iss_op` within the five defined codes. They also assume it holds an instruction unchanged while `iss_stall` is high, and that the base register of a load or store is ready when it issues, because address formation uses the register value directly. The directed stimulus seeds registers only with add-immediate from register 0. It waits for every producer of a base register to broadcast before issuing a memory operation, and it re-presents stalled instructions cycle after cycle until they are accepted.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  localparam int XLEN  = 32;
  localparam int IMM_W = 12;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_ADDI  = 3'd2,
    OP_MUL   = 3'd3,
    OP_BNE   = 3'd4
  } rs_op_e;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] imm);
    return {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] mul_lo(input logic [XLEN-1:0] a,
                                             input logic [XLEN-1:0] b);
    logic signed [2*XLEN-1:0] prod;
    prod = $signed({{XLEN{a[XLEN-1]}}, a}) * $signed({{XLEN{b[XLEN-1]}}, b});
    return prod[XLEN-1:0];
  endfunction

  // Result of a station for its operation; loads take memory data elsewhere.
  function automatic logic [XLEN-1:0] alu_result(input rs_op_e op,
                                                 input logic [XLEN-1:0] vj,
                                                 input logic [XLEN-1:0] vk,
                                                 input logic [XLEN-1:0] imm);
    case (op)
      OP_ADDI:  return vj + imm;
      OP_MUL:   return mul_lo(vj, vk);
      OP_BNE:   return (vj != vk) ? {{(XLEN-1){1'b0}}, 1'b1} : '0;
      OP_STORE: return vk;
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/rsp_arbiter.sv
module rsp_arbiter #(
  parameter int N     = 11,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    grant_o = '0;
    any_o   = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !any_o) begin
        grant_o[i] = 1'b1;
        any_o      = 1'b1;
        idx_o      = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rsp_regstat.sv
module rsp_regstat #(
  parameter int NREG  = 32,
  parameter int TAG_W = 4,
  parameter int DW    = 32,
  localparam int RA_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RA_W-1:0]  ra1_i,
  input  logic [RA_W-1:0]  ra2_i,
  input  logic [RA_W-1:0]  ra3_i,
  output logic [TAG_W-1:0] tag1_o,
  output logic [DW-1:0]    val1_o,
  output logic [TAG_W-1:0] tag2_o,
  output logic [DW-1:0]    val2_o,
  output logic [TAG_W-1:0] tag3_o,
  output logic [DW-1:0]    val3_o,
  input  logic             set_en_i,
  input  logic [RA_W-1:0]  set_idx_i,
  input  logic [TAG_W-1:0] set_tag_i,
  input  logic             bc_valid_i,
  input  logic [TAG_W-1:0] bc_tag_i,
  input  logic [DW-1:0]    bc_data_i
);
  logic [TAG_W-1:0] tag_q [NREG];
  logic [DW-1:0]    val_q [NREG];

  always_ff @(posedge clk) begin
    for (int e = 0; e < NREG; e++) begin
      if (!rst_n) begin
        tag_q[e] <= '0;
        val_q[e] <= '0;
      end else if (set_en_i && (set_idx_i == RA_W'(e))) begin
        tag_q[e] <= set_tag_i;
      end else if (bc_valid_i && (tag_q[e] != '0) && (tag_q[e] == bc_tag_i)) begin
        tag_q[e] <= '0;
        val_q[e] <= bc_data_i;
      end
    end
  end

  assign tag1_o = tag_q[ra1_i];
  assign val1_o = val_q[ra1_i];
  assign tag2_o = tag_q[ra2_i];
  assign val2_o = val_q[ra2_i];
  assign tag3_o = tag_q[ra3_i];
  assign val3_o = val_q[ra3_i];
endmodule

// File: rtl/rsp_station.sv
module rsp_station
  import rsp_pkg::*;
#(
  parameter int TAG_W        = 4,
  parameter int CNT_W        = 4,
  parameter int LAT_MEM      = 2,
  parameter int LAT_ADD      = 2,
  parameter int LAT_MUL      = 10,
  parameter int LAT_BR_READY = 1,
  parameter int LAT_BR_WAKE  = 2,
  parameter bit SNOOP        = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_i,
  input  rs_op_e           op_i,
  input  logic [TAG_W-1:0] qj_i,
  input  logic [TAG_W-1:0] qk_i,
  input  logic [XLEN-1:0]  vj_i,
  input  logic [XLEN-1:0]  vk_i,
  input  logic [XLEN-1:0]  imm_i,
  input  logic [XLEN-1:0]  addr_i,
  input  logic             bc_valid_i,
  input  logic [TAG_W-1:0] bc_tag_i,
  input  logic [XLEN-1:0]  bc_data_i,
  input  logic             grant_i,
  output logic             busy_o,
  output logic             req_o,
  output logic [XLEN-1:0]  result_o,
  output logic [XLEN-1:0]  addr_o
);
  logic             busy_q;
  rs_op_e           op_q;
  logic [TAG_W-1:0] qj_q, qk_q;
  logic [XLEN-1:0]  vj_q, vk_q, imm_q, addr_q;
  logic [CNT_W-1:0] cnt_q;

  logic hit_j, hit_k, pending, fill_last;

  function automatic logic [CNT_W-1:0] lat_of(input rs_op_e op, input logic woken);
    case (op)
      OP_LOAD, OP_STORE: return CNT_W'(LAT_MEM);
      OP_ADDI:           return CNT_W'(LAT_ADD);
      OP_MUL:            return CNT_W'(LAT_MUL);
      OP_BNE:            return woken ? CNT_W'(LAT_BR_WAKE) : CNT_W'(LAT_BR_READY);
      default:           return CNT_W'(LAT_ADD);
    endcase
  endfunction

  always_comb begin
    hit_j     = SNOOP && bc_valid_i && (qj_q != '0) && (qj_q == bc_tag_i);
    hit_k     = SNOOP && bc_valid_i && (qk_q != '0) && (qk_q == bc_tag_i);
    pending   = (qj_q != '0) || (qk_q != '0);
    fill_last = pending && ((qj_q == '0) || hit_j) && ((qk_q == '0) || hit_k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_LOAD;
      qj_q   <= '0;
      qk_q   <= '0;
      vj_q   <= '0;
      vk_q   <= '0;
      imm_q  <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (alloc_i) begin
      busy_q <= 1'b1;
      op_q   <= op_i;
      qj_q   <= qj_i;
      qk_q   <= qk_i;
      vj_q   <= vj_i;
      vk_q   <= vk_i;
      imm_q  <= imm_i;
      addr_q <= addr_i;
      cnt_q  <= ((qj_i == '0) && (qk_i == '0)) ? lat_of(op_i, 1'b0) : '0;
    end else if (busy_q) begin
      if (grant_i) begin
        busy_q <= 1'b0;
      end else begin
        if (hit_j) begin
          vj_q <= bc_data_i;
          qj_q <= '0;
        end
        if (hit_k) begin
          vk_q <= bc_data_i;
          qk_q <= '0;
        end
        if (fill_last) begin
          cnt_q <= lat_of(op_q, 1'b1);
        end else if (!pending && (cnt_q != '0)) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign req_o    = busy_q && !pending && (cnt_q == '0);
  assign result_o = alu_result(op_q, vj_q, vk_q, imm_q);
  assign addr_o   = addr_q;
endmodule

// File: rtl/rsp_pool.sv
module rsp_pool
  import rsp_pkg::*;
#(
  parameter int N_LOAD       = 3,
  parameter int N_STORE      = 3,
  parameter int N_ADD        = 3,
  parameter int N_MUL        = 2,
  parameter int NREG         = 32,
  parameter int LAT_MEM      = 2,
  parameter int LAT_ADD      = 2,
  parameter int LAT_MUL      = 10,
  parameter int LAT_BR_READY = 1,
  parameter int LAT_BR_WAKE  = 2,
  localparam int N_ST    = N_LOAD + N_STORE + N_ADD + N_MUL,
  localparam int TAG_W   = $clog2(N_ST + 1),
  localparam int IDX_W   = $clog2(N_ST),
  localparam int RA_W    = $clog2(NREG),
  localparam int LAT_MAX = (LAT_MUL > LAT_MEM) ? LAT_MUL : LAT_MEM,
  localparam int CNT_W   = $clog2(LAT_MAX + LAT_ADD + LAT_BR_WAKE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [2:0]       iss_op,
  input  logic [RA_W-1:0]  iss_rd,
  input  logic [RA_W-1:0]  iss_rs1,
  input  logic [RA_W-1:0]  iss_rs2,
  input  logic [IMM_W-1:0] iss_imm,
  output logic             iss_stall,
  output logic [TAG_W-1:0] iss_tag,
  output logic             cdb_valid,
  output logic [TAG_W-1:0] cdb_tag,
  output logic [XLEN-1:0]  cdb_data,
  output logic [XLEN-1:0]  mem_rd_addr,
  input  logic [XLEN-1:0]  mem_rd_data,
  output logic             mem_wr_en,
  output logic [XLEN-1:0]  mem_wr_addr,
  output logic [XLEN-1:0]  mem_wr_data,
  input  logic [RA_W-1:0]  rf_sel,
  output logic [TAG_W-1:0] rf_tag,
  output logic [XLEN-1:0]  rf_value
);
  localparam int B_STORE = N_LOAD;
  localparam int B_ADD   = N_LOAD + N_STORE;
  localparam int B_MUL   = N_LOAD + N_STORE + N_ADD;

  rs_op_e op;
  logic   op_ok;
  int     cls_lo, cls_hi;

  logic [N_ST-1:0]  st_busy, st_req, st_alloc, cls_mask;
  logic [N_ST-1:0]  alloc_grant, bc_grant;
  logic             alloc_any, bc_any;
  logic [IDX_W-1:0] alloc_idx, win_idx;
  logic [XLEN-1:0]  st_result [N_ST];
  logic [XLEN-1:0]  st_addr   [N_ST];

  logic             iss_fire, win_is_load, win_is_store;
  logic [TAG_W-1:0] rf_tag1, rf_tag2;
  logic [XLEN-1:0]  rf_val1, rf_val2;
  logic             r1_rdy, r2_rdy;
  logic [TAG_W-1:0] r1_q, r2_q;
  logic [XLEN-1:0]  r1_val, r2_val;
  logic [TAG_W-1:0] in_qj, in_qk;
  logic [XLEN-1:0]  in_vj, in_vk, in_imm, in_addr;
  logic             dest_wr;

  // Class range of the presented operation.
  always_comb begin
    op     = rs_op_e'(iss_op);
    op_ok  = 1'b1;
    cls_lo = 0;
    cls_hi = 0;
    case (op)
      OP_LOAD:         begin cls_lo = 0;       cls_hi = B_STORE; end
      OP_STORE:        begin cls_lo = B_STORE; cls_hi = B_ADD;   end
      OP_ADDI, OP_BNE: begin cls_lo = B_ADD;   cls_hi = B_MUL;   end
      OP_MUL:          begin cls_lo = B_MUL;   cls_hi = N_ST;    end
      default:         op_ok = 1'b0;
    endcase
    for (int i = 0; i < N_ST; i++) begin
      cls_mask[i] = (i >= cls_lo) && (i < cls_hi);
    end
  end

  rsp_arbiter #(.N(N_ST), .IDX_W(IDX_W)) u_alloc_pick (
    .req_i   (~st_busy & cls_mask),
    .grant_o (alloc_grant),
    .any_o   (alloc_any),
    .idx_o   (alloc_idx)
  );

  assign iss_fire  = iss_valid && op_ok && alloc_any;
  assign iss_stall = iss_valid && op_ok && !alloc_any;
  assign iss_tag   = alloc_any ? (TAG_W'(alloc_idx) + TAG_W'(1)) : '0;
  assign st_alloc  = iss_fire ? alloc_grant : '0;

  // Broadcast selection: lowest finished station wins.
  rsp_arbiter #(.N(N_ST), .IDX_W(IDX_W)) u_bc_pick (
    .req_i   (st_req),
    .grant_o (bc_grant),
    .any_o   (bc_any),
    .idx_o   (win_idx)
  );

  assign win_is_load  = win_idx < IDX_W'(B_STORE);
  assign win_is_store = (win_idx >= IDX_W'(B_STORE)) && (win_idx < IDX_W'(B_ADD));

  assign cdb_valid   = bc_any;
  assign cdb_tag     = bc_any ? (TAG_W'(win_idx) + TAG_W'(1)) : '0;
  assign mem_rd_addr = (bc_any && win_is_load) ? st_addr[win_idx] : '0;
  assign cdb_data    = !bc_any ? '0 : (win_is_load ? mem_rd_data : st_result[win_idx]);
  assign mem_wr_en   = bc_any && win_is_store;
  assign mem_wr_addr = st_addr[win_idx];
  assign mem_wr_data = st_result[win_idx];

  rsp_regstat #(.NREG(NREG), .TAG_W(TAG_W), .DW(XLEN)) u_regstat (
    .clk        (clk),
    .rst_n      (rst_n),
    .ra1_i      (iss_rs1),
    .ra2_i      (iss_rs2),
    .ra3_i      (rf_sel),
    .tag1_o     (rf_tag1),
    .val1_o     (rf_val1),
    .tag2_o     (rf_tag2),
    .val2_o     (rf_val2),
    .tag3_o     (rf_tag),
    .val3_o     (rf_value),
    .set_en_i   (dest_wr),
    .set_idx_i  (iss_rd),
    .set_tag_i  (iss_tag),
    .bc_valid_i (cdb_valid),
    .bc_tag_i   (cdb_tag),
    .bc_data_i  (cdb_data)
  );

  // Source resolution, with a bypass from the broadcast of this cycle.
  always_comb begin
    r1_rdy = (rf_tag1 == '0) || (cdb_valid && (cdb_tag == rf_tag1));
    r2_rdy = (rf_tag2 == '0) || (cdb_valid && (cdb_tag == rf_tag2));
    r1_val = (rf_tag1 == '0) ? rf_val1 : (r1_rdy ? cdb_data : '0);
    r2_val = (rf_tag2 == '0) ? rf_val2 : (r2_rdy ? cdb_data : '0);
    r1_q   = r1_rdy ? '0 : rf_tag1;
    r2_q   = r2_rdy ? '0 : rf_tag2;

    in_imm  = sext_imm(iss_imm);
    in_addr = r1_val + in_imm;
    in_qj   = '0;
    in_qk   = '0;
    in_vj   = '0;
    in_vk   = '0;
    case (op)
      OP_STORE: begin
        in_qk = r2_q;
        in_vk = r2_val;
      end
      OP_ADDI: begin
        in_qj = r1_q;
        in_vj = r1_val;
      end
      OP_MUL, OP_BNE: begin
        in_qj = r1_q;
        in_vj = r1_val;
        in_qk = r2_q;
        in_vk = r2_val;
      end
      default: ;
    endcase
    dest_wr = iss_fire && (iss_rd != '0) &&
              ((op == OP_LOAD) || (op == OP_ADDI) || (op == OP_MUL));
  end

  for (genvar g = 0; g < N_ST; g++) begin : g_st
    rsp_station #(
      .TAG_W        (TAG_W),
      .CNT_W        (CNT_W),
      .LAT_MEM      (LAT_MEM),
      .LAT_ADD      (LAT_ADD),
      .LAT_MUL      (LAT_MUL),
      .LAT_BR_READY (LAT_BR_READY),
      .LAT_BR_WAKE  (LAT_BR_WAKE),
      .SNOOP        (g >= N_LOAD)
    ) u_st (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_i    (st_alloc[g]),
      .op_i       (op),
      .qj_i       (in_qj),
      .qk_i       (in_qk),
      .vj_i       (in_vj),
      .vk_i       (in_vk),
      .imm_i      (in_imm),
      .addr_i     (in_addr),
      .bc_valid_i (cdb_valid),
      .bc_tag_i   (cdb_tag),
      .bc_data_i  (cdb_data),
      .grant_i    (bc_grant[g]),
      .busy_o     (st_busy[g]),
      .req_o      (st_req[g]),
      .result_o   (st_result[g]),
      .addr_o     (st_addr[g])
    );
  end
endmodule

// File: rtl/rsp_pool_chk.sv
module rsp_pool_chk #(
  parameter int N_ST    = 11,
  parameter int TAG_W   = 4,
  parameter int N_LOAD  = 3,
  parameter int N_STORE = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_ST-1:0]  st_busy,
  input logic [N_ST-1:0]  st_alloc,
  input logic [N_ST-1:0]  bc_grant,
  input logic             iss_fire,
  input logic             iss_stall,
  input logic             cdb_valid,
  input logic [TAG_W-1:0] cdb_tag,
  input logic             mem_wr_en
);
  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bc_grant));

  // R2
  alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire |-> (($countones(st_alloc) == 1) && ((st_alloc & st_busy) == '0)));

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_stall |=> ((st_busy & ~$past(st_busy)) == '0));

  // R9
  store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (cdb_valid && (cdb_tag > TAG_W'(N_LOAD)) &&
                   (cdb_tag <= TAG_W'(N_LOAD + N_STORE))));

  // R12
  free_after_bc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |=> ((st_busy & $past(bc_grant)) == '0));
endmodule

bind rsp_pool rsp_pool_chk #(
  .N_ST    (N_ST),
  .TAG_W   (TAG_W),
  .N_LOAD  (N_LOAD),
  .N_STORE (N_STORE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st_busy   (st_busy),
  .st_alloc  (st_alloc),
  .bc_grant  (bc_grant),
  .iss_fire  (iss_fire),
  .iss_stall (iss_stall),
  .cdb_valid (cdb_valid),
  .cdb_tag   (cdb_tag),
  .mem_wr_en (mem_wr_en)
);

// File: tb/rsp_pool_tb.sv
`timescale 1ns/100ps
module rsp_pool_tb;
  localparam logic [2:0] LD = 3'd0, ST = 3'd1, AI = 3'd2, MU = 3'd3, BN = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [2:0]  iss_op = '0;
  logic [4:0]  iss_rd = '0, iss_rs1 = '0, iss_rs2 = '0, rf_sel = '0;
  logic [11:0] iss_imm = '0;
  logic        iss_stall, cdb_valid, mem_wr_en;
  logic [3:0]  iss_tag, cdb_tag, rf_tag;
  logic [31:0] cdb_data, mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data, rf_value;

  logic [31:0] mem [0:63];
  int cyc = 0;
  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rsp_pool u_dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_rd(iss_rd), .iss_rs1(iss_rs1), .iss_rs2(iss_rs2), .iss_imm(iss_imm),
    .iss_stall(iss_stall), .iss_tag(iss_tag), .cdb_valid(cdb_valid),
    .cdb_tag(cdb_tag), .cdb_data(cdb_data), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .rf_sel(rf_sel), .rf_tag(rf_tag), .rf_value(rf_value)
  );

  assign mem_rd_data = mem[mem_rd_addr[7:2]];
  always @(posedge clk) if (mem_wr_en) mem[mem_wr_addr[7:2]] <= mem_wr_data;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
    #0.2;
  endtask

  // Called at a negedge; returns at the negedge after the accepting edge.
  task automatic do_issue(input logic [2:0] op, input int rd, input int rs1, input int rs2,
                          input logic [11:0] imm, output logic [3:0] tag, output int ic);
    iss_op = op; iss_rd = 5'(rd); iss_rs1 = 5'(rs1); iss_rs2 = 5'(rs2); iss_imm = imm;
    iss_valid = 1'b1;
    #0.2;
    while (iss_stall) begin
      @(negedge clk);
      #0.2;
    end
    tag = iss_tag;
    @(posedge clk);
    @(negedge clk);
    iss_valid = 1'b0;
    ic = cyc;
  endtask

  task automatic chk_bc(input string req, input int c, input logic [3:0] tag,
                        input logic [31:0] data);
    wait_until(c);
    chk({req, " valid"}, 32'(cdb_valid), 32'd1);
    chk({req, " tag"}, 32'(cdb_tag), 32'(tag));
    chk({req, " data"}, cdb_data, data);
  endtask

  task automatic chk_rf(input string req, input int idx, input logic [3:0] tag,
                        input logic [31:0] val, input bit with_val);
    rf_sel = 5'(idx);
    #0.2;
    chk({req, " rf tag"}, 32'(rf_tag), 32'(tag));
    if (with_val) chk({req, " rf value"}, rf_value, val);
  endtask

  task automatic t_reset;
    chk("R1 no broadcast", 32'(cdb_valid), 32'd0);
    chk("R1 no store", 32'(mem_wr_en), 32'd0);
    chk_rf("R1 x1", 1, 4'd0, 32'd0, 1'b1);
    chk_rf("R1 x31", 31, 4'd0, 32'd0, 1'b1);
  endtask

  task automatic t_addi;
    logic [3:0] t; int ic;
    do_issue(AI, 1, 0, 0, 12'd5, t, ic);
    chk("R2 addi tag", 32'(t), 32'd7);
    chk_rf("R4 x1 tagged", 1, 4'd7, 32'd0, 1'b0);
    wait_until(ic + 1);
    chk("R5 addi not early", 32'(cdb_valid), 32'd0);
    chk_bc("R5 R11 addi", ic + 2, 4'd7, 32'd5);
    wait_until(ic + 3);
    chk_rf("R7 x1 filled", 1, 4'd0, 32'd5, 1'b1);
    do_issue(AI, 2, 0, 0, 12'hFFD, t, ic);
    chk_bc("R11 addi sext", ic + 2, 4'd7, 32'hFFFF_FFFD);
    wait_until(ic + 3);
    do_issue(AI, 0, 0, 0, 12'd9, t, ic);
    chk_rf("R4 x0 not tagged", 0, 4'd0, 32'd0, 1'b1);
    wait_until(ic + 3);
    chk_rf("R4 x0 stays zero", 0, 4'd0, 32'd0, 1'b1);
  endtask

  task automatic t_mul;
    logic [3:0] t; int ic;
    do_issue(MU, 3, 1, 2, 12'd0, t, ic);
    chk("R2 mul tag", 32'(t), 32'd10);
    wait_until(ic + 9);
    chk("R5 mul not early", 32'(cdb_valid), 32'd0);
    chk_bc("R5 R11 mul signed", ic + 10, 4'd10, 32'hFFFF_FFF1);
    wait_until(ic + 2 + 10);
  endtask

  task automatic t_wake;
    logic [3:0] t1, t2, t3; int i1, i2, i3, m;
    do_issue(MU, 4, 1, 1, 12'd0, t1, i1);
    do_issue(AI, 5, 4, 0, 12'd1, t2, i2);
    do_issue(ST, 0, 0, 4, 12'd8, t3, i3);
    chk("R2 store tag", 32'(t3), 32'd4);
    chk("R2 waiting addi tag", 32'(t2), 32'd7);
    m = i1 + 10;
    chk_bc("R6 producer", m, 4'd10, 32'd25);
    wait_until(m + 2);
    chk("R6 woken not early", 32'(cdb_valid), 32'd0);
    chk_bc("R8 R6 store wins", m + 3, 4'd4, 32'd25);
    chk("R9 wr en", 32'(mem_wr_en), 32'd1);
    chk("R9 wr addr", mem_wr_addr, 32'd8);
    chk("R9 wr data", mem_wr_data, 32'd25);
    chk_bc("R8 addi held then sent", m + 4, 4'd7, 32'd26);
    chk("R9 memory written", mem[2], 32'd25);
    wait_until(m + 5);
    chk_rf("R7 x5", 5, 4'd0, 32'd26, 1'b1);
  endtask

  task automatic t_branch;
    logic [3:0] t; int ic, m;
    do_issue(BN, 0, 1, 2, 12'd0, t, ic);
    chk_bc("R5 R11 bne taken", ic + 1, 4'd7, 32'd1);
    wait_until(ic + 2);
    do_issue(BN, 0, 1, 1, 12'd0, t, ic);
    chk_bc("R11 bne equal", ic + 1, 4'd7, 32'd0);
    wait_until(ic + 2);
    do_issue(MU, 6, 1, 1, 12'd0, t, m);
    do_issue(BN, 0, 6, 1, 12'd0, t, ic);
    chk_bc("R6 producer", m + 10, 4'd10, 32'd25);
    wait_until(m + 12);
    chk("R6 woken bne not early", 32'(cdb_valid), 32'd0);
    chk_bc("R6 woken bne", m + 13, 4'd7, 32'd1);
    wait_until(m + 15);
  endtask

  task automatic t_load;
    logic [3:0] t; int ic;
    do_issue(LD, 7, 0, 0, 12'd8, t, ic);
    chk("R2 load tag", 32'(t), 32'd1);
    chk_bc("R10 load", ic + 2, 4'd1, 32'd25);
    chk("R10 rd addr", mem_rd_addr, 32'd8);
    wait_until(ic + 3);
    chk_rf("R7 x7", 7, 4'd0, 32'd25, 1'b1);
  endtask

  task automatic t_stall;
    logic [3:0] t1, t2, t3, ta, tb; int a, i2, i3, ia, ib;
    do_issue(AI, 15, 0, 0, 12'd1, ta, ia);
    do_issue(AI, 16, 0, 0, 12'd2, tb, ib);
    chk("R2 lowest free add", 32'(tb), 32'd8);
    do_issue(MU, 12, 1, 1, 12'd0, t1, a);
    do_issue(MU, 13, 1, 1, 12'd0, t2, i2);
    chk("R2 second mul tag", 32'(t2), 32'd11);
    iss_op = MU; iss_rd = 5'd14; iss_rs1 = 5'd1; iss_rs2 = 5'd1; iss_imm = '0;
    iss_valid = 1'b1;
    #0.2;
    chk("R3 stall", 32'(iss_stall), 32'd1);
    chk_rf("R3 x14 untouched", 14, 4'd0, 32'd0, 1'b0);
    do_issue(MU, 14, 1, 1, 12'd0, t3, i3);
    chk("R3 R12 accept cycle", 32'(i3), 32'(a + 12));
    chk("R2 R12 reused tag", 32'(t3), 32'd10);
    chk_bc("R3 held mul result", i3 + 10, 4'd10, 32'd25);
    wait_until(i3 + 12);
  endtask

  task automatic t_bypass;
    logic [3:0] t; int b, ic;
    do_issue(MU, 9, 1, 1, 12'd0, t, b);
    wait_until(b + 10);
    chk("R4 bypass source broadcasting", 32'(cdb_tag), 32'd10);
    do_issue(AI, 10, 9, 0, 12'd0, t, ic);
    chk("R4 bypass issue cycle", 32'(ic), 32'(b + 11));
    chk_bc("R4 bypass value", ic + 2, 4'd7, 32'd25);
    wait_until(ic + 3);
  endtask

  task automatic t_overwrite;
    logic [3:0] t; int c, ic;
    do_issue(MU, 11, 1, 1, 12'd0, t, c);
    do_issue(AI, 11, 0, 0, 12'd3, t, ic);
    chk_rf("R7 newest tag", 11, 4'd7, 32'd0, 1'b0);
    chk_bc("R7 mul broadcast", c + 10, 4'd10, 32'd25);
    wait_until(c + 11);
    chk_rf("R7 stale result ignored", 11, 4'd0, 32'd3, 1'b1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #0.2;
    t_reset();
    t_addi();
    t_mul();
    t_wake();
    t_branch();
    t_load();
    t_stall();
    t_bypass();
    t_overwrite();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule